// File: doc/BRIEF.md
# Serial RGB Display Window Capture

This block sits behind the pixel input of a small delta-arranged colour panel. It receives a stream of 6-bit sub-pixels, one per clock, together with active-low horizontal and vertical sync. It counts clocks from each horizontal sync falling edge and lines from each vertical sync falling edge. From those two counts it selects the visible window. Each sub-pixel inside the window comes out with its column index, its row index and a colour tag: red, green or blue, in arrival order.

Two scan-direction inputs mirror the indices independently. One mirrors the rows (top/bottom) and the other mirrors the columns (left/right), so the same stream can be drawn on a panel mounted the other way round. The block also measures the number of lines in each field and reports whether that count lies inside the accepted range. A standby input suppresses pixel output. The active-low reset input acts as the global reset for all the logic.

The window geometry is set by parameters. The defaults give a first datum on clock 269 after the sync edge, 280 data clocks per line, a first row 25 lines after the field edge, 220 rows, and an accepted field length of 256 to 268 lines.

Top module: `rgb_window_capture`

## Requirements
- R1: `pix_in` (6 bits, bit 5 most significant) is sampled on the rising clock edge. A sample inside the window appears on `pix_data` with `pix_valid` high in the clock cycle that follows that edge.
- R2: The first edge on which `hsync_n` is sampled low after being high is clock 1 of the line. Clocks H_START+1 to H_START+ACT_W (default 269 to 548) are the only clocks of a line that can produce a valid pixel.
- R3: `pix_phase` tags each valid pixel 0 = red, 1 = green, 2 = blue. The tags repeat in that order and restart at red on the first datum of every line.
- R4: With `scan_lr` high, `pix_col` counts 0 to ACT_W-1 across the line. With `scan_lr` low, the column is mirrored to ACT_W-1 minus that count.
- R5: A `vsync_n` falling edge sets the line number to 0, and each `hsync_n` falling edge adds one. If both edges fall on the same clock, the vertical edge wins. Lines V_START to V_START+ACT_H-1 are the visible rows, and with `scan_ud` low, `pix_row` equals the line number minus V_START.
- R6: With `scan_ud` high, the row index is mirrored to ACT_H-1 minus the unmirrored row. Row and column mirroring are independent of each other.
- R7: While `stby_n` is low, no pixel is marked valid. Sync counting and field measurement continue.
- R8: `rst_n` low on a clock edge clears all outputs to 0. After reset, no pixel is valid until at least one falling edge of each sync has been seen.
- R9: On each `vsync_n` falling edge after the first since reset, the count of `hsync_n` falling edges since the previous one is checked against LINE_MIN..LINE_MAX (default 256..268). In range gives `tim_ok`=1 and `tim_err`=0; out of range gives the reverse. Both are 0 until the first measurement, and both change in the cycle after that edge.
- R10: While `pix_valid` is low, `pix_data`, `pix_col`, `pix_row` and `pix_phase` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low global reset |
| stby_n | input | 1 | Low selects standby (no pixel output) |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| scan_ud | input | 1 | High mirrors row indices (bottom to top) |
| scan_lr | input | 1 | High scans left to right; low mirrors columns |
| pix_in | input | 6 | Serial sub-pixel data |
| pix_valid | output | 1 | Sub-pixel on the outputs lies inside the window |
| pix_data | output | 6 | Captured sub-pixel |
| pix_col | output | $clog2(ACT_W) | Column index after mirroring |
| pix_row | output | $clog2(ACT_H) | Row index after mirroring |
| pix_phase | output | 2 | Colour tag: 0 red, 1 green, 2 blue |
| tim_ok | output | 1 | Last measured field length in range |
| tim_err | output | 1 | Last measured field length out of range |

## Verification
Every pixel result is due in the cycle directly after the rising edge that sampled its data and syncs. The bench therefore drives each input on the falling clock edge and reads the outputs one nanosecond after the next rising edge, comparing them against that one clock's expectations. Field status is due in the cycle after the vertical sync edge, so the frame task reads it right after the edge on which `vsync_n` first goes low. The field length it expects is the line count of the previous frame, which the bench keeps itself.

// File: rtl/swc_pkg.sv
// Shared types for the serial RGB window capture.
// Assumes sub-pixels arrive in red, green, blue order, one per clock.
package swc_pkg;
    typedef enum logic [1:0] {
        PH_R = 2'd0,
        PH_G = 2'd1,
        PH_B = 2'd2
    } phase_e;
endpackage

// File: rtl/swc_hcount.sv
// Horizontal timing: detects the hsync falling edge, numbers the clocks of
// the line (clock 1 = edge that first sees hsync low) and flags the
// horizontal window with its raw column and colour phase.
// Assumes H_START >= 1 and a saturating counter wide enough for the window.
module swc_hcount
    import swc_pkg::*;
#(
    parameter int H_START = 268,
    parameter int ACT_W   = 280,
    parameter int HW      = 10,
    parameter int CW      = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_n,
    output logic          hs_fall,
    output logic          h_act,
    output logic [CW-1:0] col_raw,
    output phase_e        phase
);
    localparam logic [HW-1:0] HMAX    = '1;
    localparam logic [HW-1:0] H_FIRST = HW'(H_START + 1);
    localparam logic [HW-1:0] H_LAST  = HW'(H_START + ACT_W);

    logic          hs_q;
    logic [HW-1:0] hcnt;
    logic [HW-1:0] k;
    phase_e        ph_q;
    phase_e        nxt_ph;

    // Purpose: number of the current clock within the line.
    always_comb begin
        hs_fall = hs_q & ~hsync_n;
        if (hs_fall)
            k = HW'(1);
        else if (hcnt == HMAX)
            k = HMAX;
        else
            k = hcnt + 1'b1;
    end

    // Purpose: window flag, raw column and colour phase of this clock.
    always_comb begin
        h_act   = (k >= H_FIRST) && (k <= H_LAST);
        col_raw = CW'(k - H_FIRST);
        phase   = (k == H_FIRST) ? PH_R : ph_q;
        case (phase)
            PH_R:    nxt_ph = PH_G;
            PH_G:    nxt_ph = PH_B;
            default: nxt_ph = PH_R;
        endcase
    end

    // Purpose: remember sync level, clock number and next colour phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= 1'b1;
            hcnt <= HMAX;
            ph_q <= PH_R;
        end else begin
            hs_q <= hsync_n;
            hcnt <= k;
            if (h_act)
                ph_q <= nxt_ph;
        end
    end
endmodule

// File: rtl/swc_vcount.sv
// Vertical timing: numbers the lines from the vsync falling edge, flags the
// visible rows and judges each complete field's line count.
// Assumes LINE_MAX >= V_START + ACT_H so the counter covers every row.
module swc_vcount #(
    parameter int V_START  = 25,
    parameter int ACT_H    = 220,
    parameter int LINE_MIN = 256,
    parameter int LINE_MAX = 268,
    parameter int LW       = 9,
    parameter int RW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vsync_n,
    input  logic          hs_fall,
    output logic          v_act,
    output logic [RW-1:0] row_raw,
    output logic          tim_ok,
    output logic          tim_err
);
    localparam logic [LW-1:0] LMAX    = '1;
    localparam logic [LW-1:0] V_FIRST = LW'(V_START);
    localparam logic [LW-1:0] V_LAST  = LW'(V_START + ACT_H - 1);
    localparam logic [LW-1:0] F_MIN   = LW'(LINE_MIN);
    localparam logic [LW-1:0] F_MAX   = LW'(LINE_MAX);

    logic          vs_q;
    logic          vs_fall;
    logic          seen_q;
    logic [LW-1:0] line_cnt;
    logic          in_range;

    // Purpose: edge detect, row window and field length judgement.
    always_comb begin
        vs_fall  = vs_q & ~vsync_n;
        v_act    = (line_cnt >= V_FIRST) && (line_cnt <= V_LAST);
        row_raw  = RW'(line_cnt - V_FIRST);
        in_range = (line_cnt >= F_MIN) && (line_cnt <= F_MAX);
    end

    // Purpose: line counter and field status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q     <= 1'b1;
            seen_q   <= 1'b0;
            line_cnt <= LMAX;
            tim_ok   <= 1'b0;
            tim_err  <= 1'b0;
        end else begin
            vs_q <= vsync_n;
            if (vs_fall) begin
                line_cnt <= '0;
                seen_q   <= 1'b1;
                if (seen_q) begin
                    tim_ok  <= in_range;
                    tim_err <= ~in_range;
                end
            end else if (hs_fall && (line_cnt != LMAX)) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swc_pixout.sv
// Output stage: gates the window with standby, mirrors the indices per the
// scan inputs and registers the pixel. Outputs are zero when not valid.
module swc_pixout
    import swc_pkg::*;
#(
    parameter int DW    = 6,
    parameter int ACT_W = 280,
    parameter int ACT_H = 220,
    parameter int CW    = 9,
    parameter int RW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_n,
    input  logic          scan_ud,
    input  logic          scan_lr,
    input  logic          h_act,
    input  logic          v_act,
    input  logic [CW-1:0] col_raw,
    input  logic [RW-1:0] row_raw,
    input  phase_e        phase,
    input  logic [DW-1:0] pix_in,
    output logic          pix_valid,
    output logic [DW-1:0] pix_data,
    output logic [CW-1:0] pix_col,
    output logic [RW-1:0] pix_row,
    output logic [1:0]    pix_phase
);
    localparam logic [CW-1:0] COL_TOP = CW'(ACT_W - 1);
    localparam logic [RW-1:0] ROW_TOP = RW'(ACT_H - 1);

    logic          take;
    logic [CW-1:0] col_m;
    logic [RW-1:0] row_m;

    // Purpose: decide validity and apply the mirroring.
    always_comb begin
        take  = h_act & v_act & stby_n;
        col_m = scan_lr ? col_raw : (COL_TOP - col_raw);
        row_m = scan_ud ? (ROW_TOP - row_raw) : row_raw;
    end

    // Purpose: output register, cleared outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !take) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
            pix_col   <= '0;
            pix_row   <= '0;
            pix_phase <= 2'd0;
        end else begin
            pix_valid <= 1'b1;
            pix_data  <= pix_in;
            pix_col   <= col_m;
            pix_row   <= row_m;
            pix_phase <= 2'(phase);
        end
    end
endmodule

// File: rtl/rgb_window_capture.sv
// Top: serial RGB window capture. Joins horizontal timing, vertical timing
// and the output stage. One register stage from sampled input to output.
module rgb_window_capture
    import swc_pkg::*;
#(
    parameter int DW       = 6,
    parameter int H_START  = 268,
    parameter int ACT_W    = 280,
    parameter int V_START  = 25,
    parameter int ACT_H    = 220,
    parameter int LINE_MIN = 256,
    parameter int LINE_MAX = 268,
    localparam int CW = $clog2(ACT_W),
    localparam int RW = $clog2(ACT_H),
    localparam int HW = $clog2(H_START + ACT_W + 2),
    localparam int LW = $clog2(LINE_MAX + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stby_n,
    input  logic          hsync_n,
    input  logic          vsync_n,
    input  logic          scan_ud,
    input  logic          scan_lr,
    input  logic [DW-1:0] pix_in,
    output logic          pix_valid,
    output logic [DW-1:0] pix_data,
    output logic [CW-1:0] pix_col,
    output logic [RW-1:0] pix_row,
    output logic [1:0]    pix_phase,
    output logic          tim_ok,
    output logic          tim_err
);
    logic          hs_fall;
    logic          h_act;
    logic          v_act;
    logic [CW-1:0] col_raw;
    logic [RW-1:0] row_raw;
    phase_e        phase;

    swc_hcount #(.H_START(H_START), .ACT_W(ACT_W), .HW(HW), .CW(CW)) u_h (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .hs_fall(hs_fall),
        .h_act(h_act), .col_raw(col_raw), .phase(phase)
    );

    swc_vcount #(.V_START(V_START), .ACT_H(ACT_H), .LINE_MIN(LINE_MIN),
                 .LINE_MAX(LINE_MAX), .LW(LW), .RW(RW)) u_v (
        .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .hs_fall(hs_fall),
        .v_act(v_act), .row_raw(row_raw), .tim_ok(tim_ok), .tim_err(tim_err)
    );

    swc_pixout #(.DW(DW), .ACT_W(ACT_W), .ACT_H(ACT_H), .CW(CW), .RW(RW)) u_o (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .scan_ud(scan_ud),
        .scan_lr(scan_lr), .h_act(h_act), .v_act(v_act), .col_raw(col_raw),
        .row_raw(row_raw), .phase(phase), .pix_in(pix_in),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_col(pix_col),
        .pix_row(pix_row), .pix_phase(pix_phase)
    );
endmodule

// File: rtl/swc_checker.sv
// Property checker for rgb_window_capture, attached by bind below.
module swc_checker #(
    parameter int DW    = 6,
    parameter int ACT_W = 280,
    parameter int ACT_H = 220,
    parameter int CW    = 9,
    parameter int RW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stby_n,
    input logic          scan_lr,
    input logic [DW-1:0] pix_in,
    input logic          pix_valid,
    input logic [DW-1:0] pix_data,
    input logic [CW-1:0] pix_col,
    input logic [RW-1:0] pix_row,
    input logic [1:0]    pix_phase,
    input logic          tim_ok,
    input logic          tim_err
);
    a_r1_data_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_data == $past(pix_in));

    a_r7_standby_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(stby_n));

    a_r4_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_col <= CW'(ACT_W - 1));

    a_r5_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_row <= RW'(ACT_H - 1));

    a_r3_phase_rotates: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |->
        (($past(pix_phase) == 2'd2) ? (pix_phase == 2'd0)
                                    : (pix_phase == $past(pix_phase) + 2'd1)));

    a_r4_col_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && scan_lr && $past(scan_lr)) |->
        pix_col == CW'($past(pix_col) + 1'b1));

    a_r4_col_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && !scan_lr && !$past(scan_lr)) |->
        pix_col == CW'($past(pix_col) - 1'b1));

    a_r9_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tim_ok && tim_err));

    a_r10_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_data == '0 && pix_col == '0 && pix_row == '0
                        && pix_phase == 2'd0));
endmodule

bind rgb_window_capture swc_checker #(
    .DW(DW), .ACT_W(ACT_W), .ACT_H(ACT_H), .CW(CW), .RW(RW)
) i_swc_checker (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .scan_lr(scan_lr),
    .pix_in(pix_in), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_col(pix_col), .pix_row(pix_row), .pix_phase(pix_phase),
    .tim_ok(tim_ok), .tim_err(tim_err)
);

// File: tb/test_rgb_window_capture.sv
// Directed bench for rgb_window_capture with a reduced geometry.
module test_rgb_window_capture;
    localparam int HS = 10, AW = 12, VS = 4, AH = 6, LMIN = 14, LMAX = 18;
    localparam int LEN = 26;
    localparam int CW = $clog2(AW), RW = $clog2(AH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, stby_n = 1'b1;
    logic          hsync_n = 1'b1, vsync_n = 1'b1;
    logic          scan_ud = 1'b0, scan_lr = 1'b1;
    logic [5:0]    pix_in = '0;
    logic          pix_valid;
    logic [5:0]    pix_data;
    logic [CW-1:0] pix_col;
    logic [RW-1:0] pix_row;
    logic [1:0]    pix_phase;
    logic          tim_ok, tim_err;

    int n_chk = 0, n_fail = 0;
    int prev_lines = 0;
    bit have_prev = 0;

    always #2 clk = ~clk;

    rgb_window_capture #(.DW(6), .H_START(HS), .ACT_W(AW), .V_START(VS),
        .ACT_H(AH), .LINE_MIN(LMIN), .LINE_MAX(LMAX)) i_rgb_window_capture (
        .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .scan_ud(scan_ud), .scan_lr(scan_lr),
        .pix_in(pix_in), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_col(pix_col), .pix_row(pix_row), .pix_phase(pix_phase),
        .tim_ok(tim_ok), .tim_err(tim_err));

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // One clock: drive on the falling edge, return 1 ns after the rising edge.
    task automatic drive_cycle(input logic hs, input logic vs, input logic [5:0] d);
        @(negedge clk);
        hsync_n = hs; vsync_n = vs; pix_in = d;
        @(posedge clk);
        #1;
    endtask

    task automatic check_pix(input string tag, input bit ev, input int ecol,
                             input int erow, input int eph, input logic [5:0] ed);
        bit ok;
        n_chk++;
        if (ev)
            ok = pix_valid && pix_col == CW'(ecol) && pix_row == RW'(erow)
                 && pix_phase == 2'(eph) && pix_data == ed;
        else
            ok = !pix_valid && pix_col == '0 && pix_row == '0
                 && pix_phase == 2'd0 && pix_data == '0;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b c=%0d r=%0d p=%0d d=%0d expected v=%0b c=%0d r=%0d p=%0d d=%0d",
                     tag, pix_valid, pix_col, pix_row, pix_phase, pix_data,
                     ev, ev ? ecol : 0, ev ? erow : 0, ev ? eph : 0, ev ? ed : 6'd0);
        end
    endtask

    // R9: status after a vsync fall reflects the previous field length.
    task automatic check_status(input string tag);
        bit eok, eerr;
        eok  = have_prev && prev_lines >= LMIN && prev_lines <= LMAX;
        eerr = have_prev && !(prev_lines >= LMIN && prev_lines <= LMAX);
        n_chk++;
        if (tim_ok !== eok || tim_err !== eerr) begin
            n_fail++;
            $display("FAIL R9 %s: actual ok=%0b err=%0b expected ok=%0b err=%0b",
                     tag, tim_ok, tim_err, eok, eerr);
        end
    endtask

    // One line of LEN clocks; hsync low on clocks 1 and 2 (R2, R5).
    task automatic send_line(input string tag, input int ln, input bit vs_low,
                             input bit rows_known);
        for (int k = 1; k <= LEN; k++) begin
            logic [5:0] d;
            bit act;
            int c;
            d = 6'((k * 7 + ln * 11) & 63);
            drive_cycle(k <= 2 ? 1'b0 : 1'b1, vs_low ? 1'b0 : 1'b1, d);
            act = rows_known && stby_n && ln >= VS && ln < VS + AH
                  && k >= HS + 1 && k <= HS + AW;
            c = k - HS - 1;
            check_pix(tag, act, scan_lr ? c : AW - 1 - c,
                      scan_ud ? AH - 1 - (ln - VS) : ln - VS, (c % 3 + 3) % 3, d);
        end
    endtask

    // A frame: short gap, vsync falls on gap clock 4, then n lines.
    task automatic frame(input string tag, input int n, input bit ud,
                         input bit lr, input bit sb);
        @(negedge clk);
        scan_ud = ud; scan_lr = lr; stby_n = sb;
        for (int g = 1; g <= 6; g++) begin
            drive_cycle(1'b1, g >= 4 ? 1'b0 : 1'b1, 6'h3f);
            check_pix(tag, 1'b0, 0, 0, 0, 6'd0);
            if (g == 4) check_status(tag);
        end
        for (int ln = 1; ln <= n; ln++)
            send_line(tag, ln, ln <= 2, 1'b1);
        prev_lines = n;
        have_prev  = 1;
    endtask

    // R8: synchronous reset clears everything; no pixels before a vsync.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            drive_cycle(1'b1, 1'b1, 6'h2a);
            check_pix("R8 reset", 1'b0, 0, 0, 0, 6'd0);
            n_chk++;
            if (tim_ok !== 1'b0 || tim_err !== 1'b0) begin
                n_fail++;
                $display("FAIL R8 reset status: actual ok=%0b err=%0b expected 0 0",
                         tim_ok, tim_err);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        have_prev = 0;
        scan_ud = 1'b0; scan_lr = 1'b1; stby_n = 1'b1;
        send_line("R8 no vsync yet", VS + 1, 1'b0, 1'b0);
    endtask

    task automatic t_normal();   frame("R1 R2 R3 R4 R5 normal scan", 16, 0, 1, 1); endtask
    task automatic t_reversed(); frame("R4 R6 reversed scan", 16, 1, 0, 1); endtask
    task automatic t_col_only(); frame("R4 column mirror only", 16, 0, 0, 1); endtask
    task automatic t_row_only(); frame("R6 row mirror only", 16, 1, 1, 1); endtask
    task automatic t_standby();  frame("R7 standby", 16, 0, 1, 0); endtask

    task automatic t_field_lengths();
        frame("R9 length 13", 13, 0, 1, 1);
        frame("R9 length 14", 14, 0, 1, 1);
        frame("R9 length 18", 18, 0, 1, 1);
        frame("R9 length 19", 19, 0, 1, 1);
        frame("R9 length 12", 12, 0, 1, 1);
        frame("R9 length 16", 16, 0, 1, 1);
        frame("R9 recovers", 16, 0, 1, 1);
    endtask

    initial begin
        do_reset();
        t_normal();
        t_reversed();
        t_col_only();
        t_row_only();
        t_standby();
        t_field_lengths();
        do_reset();
        frame("R8 R9 first field after reset", 16, 0, 1, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule